// File: doc/BRIEF.md
# PCI Interrupt Router with Level-to-Edge Conversion

This block steers the four active-low PCI interrupt lines (INTA through INTD) onto a 16-bit vector of ISA-style interrupt requests. Two routing bytes in configuration space give each line a 4-bit field. The field picks a target IRQ number from a fixed sparse table, or no target. It can also turn the line's level request into a one-clock pulse, so that an edge-sensitive controller downstream can take it.

The same configuration port holds a small standard header. It has identification bytes, a command register with masked writes, and a status register whose error bits clear when a 1 is written to them. Software reaches every register through a byte-wide port that carries a function number, an offset and a write strobe. A write takes effect at the next clock edge. Read data is combinational from the function number and the offset.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, offset 0x80 reads 0x80, 0x81 reads 0x00, 0x04 reads 0x07, 0x05 reads 0x00 and 0x07 reads 0x04. Offsets 0x00..0x03 read the bytes of parameter ID_WORD (default 0xC0DE1A2B, least significant byte at 0x00). Offset 0x0B reads parameter CLASS_BYTE (default 0x06). `irq_out` is 0.
- R2: A function-0 write to offset 0x04 stores (data & 0x7F) | 0x07. A write to offset 0x05 stores data & 0x01.
- R3: A function-0 write to offset 0x07 clears every stored bit where the written data has a 1 inside mask 0xB8. Bit 2 of the status byte reads 1 at all times.
- R4: Writes with a function number other than 0 are ignored. Function-0 writes to offsets 0x00..0x03, 0x06, 0x08..0x0B, 0x0F..0x2F and 0x34..0x3F are ignored. Any read with a non-zero function returns 0xFF.
- R5: A function-0 write to any other offset stores the data unchanged, and a read of that offset returns it (for example 0x0C, 0x30, 0x40, 0xFF).
- R6: Each line has a 4-bit field: INTA in 0x80[3:0], INTB in 0x80[7:4], INTC in 0x81[3:0] and INTD in 0x81[7:4]. Field bits [2:0] select the target IRQ through the table 1→5, 2→9, 3→10, 4→11, 5→12, 6→14, 7→15.
- R7: A line whose selector is 0 drives no bit of `irq_out`, whatever its level.
- R8: When field bit 3 is 0, the target bit of `irq_out` is 1 while the line is low. It follows the input two clock edges after the input changes, through a two-flop synchroniser.
- R9: When field bit 3 is 1, the target bit of `irq_out` is a one-clock pulse on each high-to-low transition of the line. The pulse starts two edges after the transition. The bit stays 0 while the line is held low and when the line goes high.
- R10: When two or more lines select the same IRQ, their requests are ORed onto that bit.
- R11: Bits 0..4, 6..8 and 13 of `irq_out` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_func | input | 3 | Function number of the access |
| cfg_off | input | 8 | Register offset of the access |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_func`/`cfg_off`, combinational |
| int_n | input | 4 | PCI interrupt lines A..D in bits 0..3, active low, asynchronous |
| irq_out | output | 16 | Interrupt request vector, bit n is IRQ n |

## Verification
Configuration reads are combinational, so the bench checks each write's effect on the falling edge right after the rising edge that took the strobe. A routing change acts on `irq_out` on that same rising edge. A change on `int_n` crosses two synchroniser flops before it reaches `irq_out`. The bench therefore drives the lines on a falling edge and samples exactly two falling edges later. In edge mode it samples once more, one edge later, to see that the pulse has ended and does not return while the line stays low.

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter logic [31:0] ID_WORD    = 32'hC0DE_1A2B,
  parameter logic [7:0]  CLASS_BYTE = 8'h06,
  parameter int          LINES      = 4,
  parameter int          IRQS       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_func,
  input  logic [7:0]       cfg_off,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [LINES-1:0] int_n,
  output logic [IRQS-1:0]  irq_out
);
  localparam int REGS = 256;
  localparam logic [7:0] OFF_CMD = 8'h04, OFF_CMDH = 8'h05, OFF_STAT = 8'h07;
  localparam logic [7:0] OFF_RT0 = 8'h80, OFF_RT1 = 8'h81;
  localparam logic [7:0] STAT_W1C = 8'hB8;

  logic [7:0] cfg_q [REGS];

  function automatic logic [7:0] reset_byte(input int a);
    case (a)
      0: return ID_WORD[7:0];
      1: return ID_WORD[15:8];
      2: return ID_WORD[23:16];
      3: return ID_WORD[31:24];
      4: return 8'h07;
      7: return 8'h04;
      11: return CLASS_BYTE;
      8'h80: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic locked(input logic [7:0] o);
    return (o < 8'h04) || (o == 8'h06) || (o >= 8'h08 && o <= 8'h0B) ||
           (o >= 8'h0F && o <= 8'h2F) || (o >= 8'h34 && o <= 8'h3F);
  endfunction

  function automatic logic [3:0] irq_num(input logic [2:0] sel);
    case (sel)
      3'd1: return 4'd5;
      3'd2: return 4'd9;
      3'd3: return 4'd10;
      3'd4: return 4'd11;
      3'd5: return 4'd12;
      3'd6: return 4'd14;
      3'd7: return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  wire wr_ok = cfg_wr && (cfg_func == 3'd0) && !locked(cfg_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < REGS; a++) cfg_q[a] <= reset_byte(a);
    end else if (wr_ok) begin
      case (cfg_off)
        OFF_CMD:  cfg_q[OFF_CMD]  <= (cfg_wdata & 8'h7F) | 8'h07;
        OFF_CMDH: cfg_q[OFF_CMDH] <= cfg_wdata & 8'h01;
        OFF_STAT: cfg_q[OFF_STAT] <= cfg_q[OFF_STAT] & ~(cfg_wdata & STAT_W1C);
        default:  cfg_q[cfg_off]  <= cfg_wdata;
      endcase
    end
  end

  assign cfg_rdata = (cfg_func != 3'd0) ? 8'hFF : cfg_q[cfg_off];

  logic [LINES-1:0] sync1, sync2, lvl_d;
  wire  [LINES-1:0] lvl   = ~sync2;
  wire  [LINES-1:0] pulse = lvl & ~lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
      lvl_d <= '0;
    end else begin
      sync1 <= int_n;
      sync2 <= sync1;
      lvl_d <= lvl;
    end
  end

  wire [15:0] route = {cfg_q[OFF_RT1], cfg_q[OFF_RT0]};

  always_comb begin
    irq_out = '0;
    for (int i = 0; i < LINES; i++) begin
      logic [3:0] fld;
      fld = route[4*i +: 4];
      if (fld[2:0] != 3'd0)
        irq_out[irq_num(fld[2:0])] = irq_out[irq_num(fld[2:0])] | (fld[3] ? pulse[i] : lvl[i]);
    end
  end
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [2:0]  cfg_func,
  input logic [7:0]  cfg_off,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [3:0]  int_n,
  input logic [15:0] irq_out
);
  localparam logic [15:0] USED_IRQS = 16'hDE20;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_out == 16'h0000);

  // R2
  cmd_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func == 3'd0 && cfg_off == 8'h04) |-> (cfg_rdata[2:0] == 3'b111 && !cfg_rdata[7]));

  // R2
  cmdh_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func == 3'd0 && cfg_off == 8'h05) |-> cfg_rdata[7:1] == 7'd0);

  // R3
  stat_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func == 3'd0 && cfg_off == 8'h07) |-> cfg_rdata[2]);

  // R4
  other_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func != 3'd0) |-> cfg_rdata == 8'hFF);

  // R11
  unused_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~USED_IRQS) == 16'h0000);
endmodule

bind pci_irq_router pci_irq_router_chk chk_i (.*);

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    32'h00_04_FF_7F, 32'h00_04_80_07, 32'h00_04_38_3F,
    32'h00_05_FF_01, 32'h00_05_FE_00, 32'h00_07_FF_04,
    32'h00_00_AA_2B, 32'h00_03_00_C0, 32'h00_06_55_00,
    32'h00_0B_00_06, 32'h00_20_77_00, 32'h00_0F_77_00,
    32'h00_36_77_00, 32'h00_40_5A_5A, 32'h00_0C_A5_A5,
    32'h00_30_3C_3C, 32'h01_40_00_FF, 32'h00_FF_81_81
  };
  localparam int TBL [8] = '{0, 5, 9, 10, 11, 12, 14, 15};

  logic clk = 0, rst_n = 0, cfg_wr = 0;
  logic [2:0] cfg_func = 0;
  logic [7:0] cfg_off = 0, cfg_wdata = 0, cfg_rdata;
  logic [3:0] int_n = 4'h0;
  logic [15:0] irq_out;
  int runs = 0, fails = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_irq_router dut_i (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] f, input logic [7:0] o, input logic [7:0] d);
    @(negedge clk);
    cfg_func = f; cfg_off = o; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_read(input logic [2:0] f, input logic [7:0] o, output logic [7:0] d);
    cfg_func = f; cfg_off = o;
    #1 d = cfg_rdata;
  endtask

  task automatic drive_int(input logic [3:0] v);
    @(negedge clk);
    int_n = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1, R7: all lines asserted but none routed
    check("R1 irq_out", irq_out, 16'h0000);
    cfg_read(0, 8'h80, rd); check("R1 rt0", rd, 8'h80);
    cfg_read(0, 8'h81, rd); check("R1 rt1", rd, 8'h00);
    cfg_read(0, 8'h04, rd); check("R1 cmd", rd, 8'h07);
    cfg_read(0, 8'h07, rd); check("R1 stat", rd, 8'h04);
    cfg_read(0, 8'h01, rd); check("R1 id1", rd, 8'h1A);
    cfg_read(0, 8'h02, rd); check("R1 id2", rd, 8'hDE);

    // R2 R3 R4 R5 vector table
    for (int k = 0; k < NV; k++) begin
      cfg_write(VEC[k][26:24], VEC[k][23:16], VEC[k][15:8]);
      cfg_read(VEC[k][26:24], VEC[k][23:16], rd);
      check($sformatf("R2/R3/R4/R5 vec%0d", k), rd, VEC[k][7:0]);
    end
    cfg_read(0, 8'h40, rd); check("R4 func1 write ignored", rd, 8'h5A);
    cfg_write(1, 8'h80, 8'h21);
    cfg_read(0, 8'h80, rd); check("R4 func1 route ignored", rd, 8'h80);
    check("R4 no route", irq_out, 16'h0000);

    // R6 R8 level routing
    drive_int(4'hF);
    cfg_write(0, 8'h80, 8'h21);
    cfg_write(0, 8'h81, 8'h73);
    drive_int(4'b1110); check("R8 INTA->5", irq_out, 16'h0020);
    drive_int(4'b1101); check("R6 INTB->9", irq_out, 16'h0200);
    drive_int(4'b1011); check("R6 INTC->10", irq_out, 16'h0400);
    drive_int(4'b0111); check("R6 INTD->15", irq_out, 16'h8000);
    drive_int(4'b0000); check("R8 all", irq_out, 16'h8620);
    drive_int(4'hF);    check("R8 release", irq_out, 16'h0000);

    // R6 R7 selector table on INTA
    cfg_write(0, 8'h81, 8'h00);
    drive_int(4'b1110);
    for (int s = 0; s < 8; s++) begin
      cfg_write(0, 8'h80, 8'(s));
      check($sformatf("R6/R7 sel%0d", s), irq_out, (s == 0) ? 16'h0 : (16'h1 << TBL[s]));
    end

    // R9 edge mode
    drive_int(4'hF);
    cfg_write(0, 8'h80, 8'h09);
    repeat (3) @(negedge clk);
    drive_int(4'b1110); check("R9 pulse", irq_out, 16'h0020);
    @(negedge clk);     check("R9 pulse end", irq_out, 16'h0000);
    repeat (3) @(negedge clk); check("R9 held low", irq_out, 16'h0000);
    drive_int(4'hF);    check("R9 release", irq_out, 16'h0000);
    @(negedge clk);     check("R9 release2", irq_out, 16'h0000);
    drive_int(4'b1110); check("R9 second pulse", irq_out, 16'h0020);
    @(negedge clk);     check("R9 second end", irq_out, 16'h0000);

    // R10 shared IRQ, R7 unrouted INTB
    drive_int(4'hF);
    cfg_write(0, 8'h80, 8'h04);
    cfg_write(0, 8'h81, 8'h04);
    drive_int(4'b1110); check("R10 INTA", irq_out, 16'h0800);
    drive_int(4'b1011); check("R10 INTC", irq_out, 16'h0800);
    drive_int(4'b1010); check("R10 both", irq_out, 16'h0800);
    drive_int(4'b1001); check("R7 INTB unrouted", irq_out, 16'h0800);
    drive_int(4'b1101); check("R7 INTB alone", irq_out, 16'h0000);
    // R11
    drive_int(4'h0);
    check("R11 unused bits", irq_out & 16'h21DF, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule